// File: doc/BRIEF.md
# Supply Fault Supervisor with First-Fault Latch

This block watches seven switched supplies on an adapter board and owns the register that turns six of them on. Each supply reports an active-high "healthy" signal. These signals are brought into the clock domain through a two-stage synchronizer. A single protection-override bit in the control register decides how the block behaves. With override set, software may program the supply-enable register and nothing trips. With override clear, protection is armed: any unhealthy input wipes the whole supply-enable register. A capture register then records which monitors were low when the trip happened.

After the first trip, the capture register holds its value. The shutdown itself makes more supplies report unhealthy, and those later faults are not added. Capture is enabled again only after override has been set and protection re-armed. The capture register keeps its last record until the next trip, so software can still read the cause after it sets override to bring the board back up. The normal bring-up sequence is:
1. Set override.
2. Write 0x3F to the supply-enable register.
3. Wait for the supplies to settle.
4. Confirm the monitor reads 0x7F.
5. Clear override.

Software reaches the registers through a byte-wide request/response port. The request channel uses valid/ready and carries a write flag, an address and write data. A read request produces one response beat on a valid/ready response channel. A write request produces no response. The block holds one response at most. While that response is pending and not accepted, it deasserts `req_ready`, so back-pressure on the response channel stalls new requests.

Top module: `supply_supervisor`

## Requirements
- R1: After reset, `supply_en` is 0, the override bit is 1 (protection disarmed), and the capture register reads 0x00.
- R2: A read at address 0x05 returns the synchronized monitor in bits 6:0, with bit 7 reading 0. A monitor change reaches the synchronized value on the second rising edge.
- R3: The control register is at address 0x02. Bit 7 is the override bit and is writable at any time. Bits 6:0 read 0.
- R4: The supply-enable register is at address 0x04. While override is 1, a write loads bits 5:0 into it, so writing 0x3F turns on all six supplies. Bits 7:6 are ignored and read 0. `supply_en` mirrors the register.
- R5: While override is 0, writes to the supply-enable register have no effect.
- R6: While override is 0, a synchronized monitor bit at 0 clears the entire supply-enable register on the next rising edge. For a change at the input, this is the third rising edge.
- R7: While override is 1, low monitor bits neither clear the supply-enable register nor change the capture register.
- R8: The first trip after arming loads the capture register at address 0x07 with the set of low monitor bits. Bit i is set when monitor bit i was 0, in the same order as the monitor register. Bit 7 reads 0.
- R9: After the first trip, later faults do not change the capture register until override has been set and cleared again.
- R10: A read response stays valid with stable data until `rsp_ready` is high. While it is pending and not taken, `req_ready` is low.
- R11: Reads at unmapped addresses return 0x00. Writes to unmapped or read-only addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mon_ok | input | 7 | Asynchronous supply-healthy monitors, active high |
| req_valid | input | 1 | Register request valid |
| req_ready | output | 1 | Register request accepted when high together with valid |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 8 | Register address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Consumer accepts the read response |
| rsp_data | output | 8 | Read response data |
| supply_en | output | 6 | Supply enables |
| prot_armed | output | 1 | High when protection is armed (override clear) |

## Verification
The assertions check four rules on every cycle:
- an armed trip empties the supply register on the following edge;
- an armed write to that register cannot load a new value;
- the capture register stays frozen once it has recorded a trip;
- a stalled response keeps its data.

Only the bench scenarios can show the rest. These cover the exact three-edge latency from a pin change to shutdown and the first-fault record itself. They also show that later faults are excluded while a record made before the disarmed window survives that window, that two supplies failing together are both recorded, and the register map's readback values.

// File: rtl/supsv_pkg.sv
package supsv_pkg;
  localparam int unsigned ADDR_W  = 8;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_MON = 7;
  localparam int unsigned NUM_SUP = 6;
  localparam int unsigned OVR_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL   = 8'h02;
  localparam logic [ADDR_W-1:0] A_SUPPLY = 8'h04;
  localparam logic [ADDR_W-1:0] A_MON    = 8'h05;
  localparam logic [ADDR_W-1:0] A_FAULT  = 8'h07;

  typedef enum logic [1:0] {
    SEL_NONE, SEL_CTRL, SEL_SUPPLY
  } wsel_e;
endpackage

// File: rtl/supsv_sync.sv
module supsv_sync #(
  parameter int unsigned W = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= d;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/supsv_core.sv
module supsv_core
  import supsv_pkg::*;
#(
  parameter int unsigned NM = NUM_MON,
  parameter int unsigned NS = NUM_SUP,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] mon_s,
  input  wsel_e         wsel,
  input  logic [DW-1:0] wdata,
  output logic          override,
  output logic          trip,
  output logic          captured,
  output logic [NS-1:0] sup_q,
  output logic [NM-1:0] fault_q
);
  logic [NM-1:0] low_vec;

  assign low_vec = ~mon_s;
  assign trip    = !override && (|low_vec);

  // override bit: always writable, resets to disarmed
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 override <= 1'b1;
    else if (wsel == SEL_CTRL)  override <= wdata[OVR_BIT];
  end

  // supply enables: shutdown wins, writes only when override is set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sup_q <= '0;
    else if (trip)
      sup_q <= '0;
    else if (override && wsel == SEL_SUPPLY)
      sup_q <= wdata[NS-1:0];
  end

  // first-fault capture; rearmed only by a pass through override
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      captured <= 1'b0;
      fault_q  <= '0;
    end else if (override) begin
      captured <= 1'b0;
    end else if (trip && !captured) begin
      captured <= 1'b1;
      fault_q  <= low_vec;
    end
  end
endmodule

// File: rtl/supsv_regport.sv
module supsv_regport
  import supsv_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W,
  parameter int unsigned NM = NUM_MON,
  parameter int unsigned NS = NUM_SUP
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  input  logic          override,
  input  logic [NS-1:0] sup_q,
  input  logic [NM-1:0] mon_s,
  input  logic [NM-1:0] fault_q,
  output wsel_e         wsel,
  output logic [DW-1:0] wdata
);
  logic          fire;
  logic [DW-1:0] rd_mux;

  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign wdata     = req_wdata;

  always_comb begin
    wsel = SEL_NONE;
    if (fire && req_write) begin
      unique case (req_addr)
        A_CTRL:   wsel = SEL_CTRL;
        A_SUPPLY: wsel = SEL_SUPPLY;
        default:  wsel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    unique case (req_addr)
      A_CTRL:   rd_mux[OVR_BIT]  = override;
      A_SUPPLY: rd_mux[NS-1:0]   = sup_q;
      A_MON:    rd_mux[NM-1:0]   = mon_s;
      A_FAULT:  rd_mux[NM-1:0]   = fault_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_mux;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import supsv_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_MON-1:0] mon_ok,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [DATA_W-1:0]  rsp_data,
  output logic [NUM_SUP-1:0] supply_en,
  output logic               prot_armed
);
  logic [NUM_MON-1:0] mon_s;
  logic [NUM_MON-1:0] fault_q;
  logic [NUM_SUP-1:0] sup_q;
  logic               override;
  logic               trip;
  logic               captured;
  wsel_e              wsel;
  logic [DATA_W-1:0]  wdata;

  supsv_sync #(.W(NUM_MON), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(mon_ok), .q(mon_s)
  );

  supsv_core u_core (
    .clk(clk), .rst_n(rst_n), .mon_s(mon_s), .wsel(wsel), .wdata(wdata),
    .override(override), .trip(trip), .captured(captured),
    .sup_q(sup_q), .fault_q(fault_q)
  );

  supsv_regport u_port (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .override(override), .sup_q(sup_q), .mon_s(mon_s), .fault_q(fault_q),
    .wsel(wsel), .wdata(wdata)
  );

  assign supply_en  = sup_q;
  assign prot_armed = !override;
endmodule

// File: rtl/supsv_chk.sv
module supsv_chk
  import supsv_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_MON-1:0] mon_s,
  input logic               override,
  input logic               captured,
  input logic [NUM_MON-1:0] fault_q,
  input logic [NUM_SUP-1:0] supply_en,
  input logic               req_valid,
  input logic               req_ready,
  input logic               req_write,
  input logic [ADDR_W-1:0]  req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [DATA_W-1:0]  rsp_data
);
  // R6
  shutdown_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!override && (mon_s != {NUM_MON{1'b1}})) |=> (supply_en == '0));

  // R5
  armed_write_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_write && req_addr == A_SUPPLY && !override)
      |=> (supply_en == $past(supply_en)) || (supply_en == '0));

  // R9
  latch_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!override && $past(!override) && $past(captured)) |-> $stable(fault_q));

  // R8
  latch_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(captured) |-> (fault_q != '0));

  // R10
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));
endmodule

bind supply_supervisor supsv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .mon_s(mon_s), .override(override),
  .captured(captured), .fault_q(fault_q), .supply_en(supply_en),
  .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_data(rsp_data)
);

// File: tb/sim_supply_supervisor.sv
`timescale 1ns/1ps
module sim_supply_supervisor;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] mon_ok = 7'h7F;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [7:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic       rsp_valid;
  logic       rsp_ready = 1'b1;
  logic [7:0] rsp_data;
  logic [5:0] supply_en;
  logic       prot_armed;

  int applied = 0;
  int miscmp = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #5 clk = ~clk;

  supply_supervisor u0 (
    .clk(clk), .rst_n(rst_n), .mon_ok(mon_ok),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .supply_en(supply_en), .prot_armed(prot_armed)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscmp++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic req(input logic wr, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    req(1'b1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    req(1'b0, a, 8'h00);
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        applied++; miscmp++;
        $display("FAIL R10 unexpected response actual=%02h expected=none", rsp_data);
      end else begin
        chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        applied++; miscmp++;
        $display("FAIL R10 missing responses actual=%0d expected=0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", applied, miscmp);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    applied++; miscmp++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    cycles(3);
    // R1 reset state
    chk("R1 supply_en", {2'b0, supply_en}, 8'h00);
    chk("R1 armed", {7'b0, prot_armed}, 8'h00);
    rd(8'h02, 8'h80, "R1 R3 ctrl reset");
    rd(8'h07, 8'h00, "R1 latch reset");
    rd(8'h05, 8'h7F, "R2 monitor healthy");

    // R3 ctrl bits
    wr(8'h02, 8'hFF);
    rd(8'h02, 8'h80, "R3 ctrl low bits read 0");

    // R4 program supplies under override
    wr(8'h04, 8'hFF);
    rd(8'h04, 8'h3F, "R4 supply reg");
    cycles(1);
    chk("R4 supply_en", {2'b0, supply_en}, 8'h3F);

    // arm, then R5 write ignored
    wr(8'h02, 8'h00);
    rd(8'h02, 8'h00, "R3 override cleared");
    wr(8'h04, 8'h00);
    rd(8'h04, 8'h3F, "R5 armed write ignored");
    cycles(1);
    chk("R5 supply_en", {2'b0, supply_en}, 8'h3F);

    // R11 unmapped
    rd(8'h30, 8'h00, "R11 unmapped read");
    wr(8'h30, 8'h00);
    wr(8'h05, 8'h00);
    wr(8'h07, 8'hFF);
    rd(8'h04, 8'h3F, "R11 supply after unmapped writes");
    rd(8'h07, 8'h00, "R11 latch after write");
    rd(8'h02, 8'h00, "R11 ctrl after writes");

    // R6 timing: monitor bit 3 low
    cycles(2);
    @(negedge clk); mon_ok = 7'h77;
    @(negedge clk); chk("R6 after edge1", {2'b0, supply_en}, 8'h3F);
    @(negedge clk); chk("R6 after edge2", {2'b0, supply_en}, 8'h3F);
    @(negedge clk); chk("R6 after edge3", {2'b0, supply_en}, 8'h00);
    // R9 later faults
    mon_ok = 7'h55;
    cycles(4);
    rd(8'h07, 8'h08, "R8 R9 first fault only");
    rd(8'h05, 8'h55, "R2 monitor faulted");

    // R7 override: no shutdown, no capture
    wr(8'h02, 8'h80);
    wr(8'h04, 8'h3F);
    cycles(5);
    chk("R7 no shutdown", {2'b0, supply_en}, 8'h3F);
    rd(8'h07, 8'h08, "R7 latch unchanged");

    // rearm, double fault (bits 1 and 5)
    mon_ok = 7'h7F;
    cycles(4);
    wr(8'h02, 8'h00);
    cycles(2);
    chk("R6 healthy armed", {2'b0, supply_en}, 8'h3F);
    @(negedge clk); mon_ok = 7'h5D;
    cycles(4);
    chk("R6 second shutdown", {2'b0, supply_en}, 8'h00);
    rd(8'h07, 8'h22, "R8 simultaneous faults");
    mon_ok = 7'h00;
    cycles(4);
    rd(8'h07, 8'h22, "R9 latch held");

    // R10 back-pressure
    cycles(2);
    @(negedge clk); rsp_ready = 1'b0;
    rd(8'h02, 8'h00, "R10 stalled response");
    chk("R10 valid held", {7'b0, rsp_valid}, 8'h01);
    chk("R10 req_ready low", {7'b0, req_ready}, 8'h00);
    cycles(3);
    chk("R10 data held", rsp_data, 8'h00);
    chk("R10 still valid", {7'b0, rsp_valid}, 8'h01);
    rsp_ready = 1'b1;
    cycles(3);
    chk("R10 drained", {7'b0, rsp_valid}, 8'h00);

    cycles(5);
    finish_run();
  end
endmodule